// File: doc/BRIEF.md
# Memory Status Register and Write-Protection Guard

This block keeps the status byte of a serial nonvolatile memory and decides which writes are allowed. It takes one-cycle strobes from the command decoder: write-enable set, write-enable clear, flag set, flag clear, and status write with its data byte. It also watches the active-low write-protect pin and the busy line of the write timer. It returns the byte that a status read shifts out, a permission bit for any array address offered to it, and a pulse that tells the timer a status write was accepted.

The nonvolatile fields are the protect-enable bit and the two-bit protection level. They are modelled as flops. An accepted status write first parks its data in a holding register. The data moves into the live bits only on the clock edge at which the timer's busy line is first seen low. At that edge the write-enable latch also clears. The protection level fences off the top quarter, the top half or the whole array. The protect pin can refuse a status write only while protect-enable is set.

Top module: `nvm_status_guard`

## Requirements
- R1: After reset the status byte reads 8'h30: bit 7 protect-enable, bit 6 flag, bits 5..4 fixed at one, bits 3..2 protection level, bit 1 write-enable latch, bit 0 write-in-progress.
- R2: Bit 0 follows `busy_i` in the same cycle, with no register delay.
- R3: A write-enable set strobe sets bit 1 from the next cycle. A write-enable clear strobe clears it from the next cycle, and wins when both strobes arrive together.
- R4: A flag set strobe makes bit 6 one and a flag clear strobe makes it zero, each from the next cycle. The clear strobe wins when both arrive together.
- R5: `wrsr_go_o` is high in the cycle of a status write strobe only when bit 1 is one, `busy_i` is low, and the pin lock is not active. The pin lock is active when bit 7 is one and `wp_n_i` is low. A refused status write changes nothing.
- R6: Held status-write data becomes visible on the edge at which `busy_i` is first sampled low after being high. Every such completion, whether of a status write or an array write, clears bit 1 on that same edge. A status write strobe that arrives while busy is refused.
- R7: When `wp_n_i` falls after a status write has been accepted, the write still completes.
- R8: While bit 7 is zero, the level of `wp_n_i` has no effect on status writes.
- R9: Of a written byte only bits 7, 3 and 2 are kept. Written bits 6, 5, 4, 1 and 0 have no effect, and bits 5 and 4 always read one.
- R10: `array_wr_ok_o` is one only when bit 1 is one, `busy_i` is low, and the address lies outside the protected range. Level 2'b00 protects nothing. Level 2'b01 protects addresses whose top two bits are 2'b11. Level 2'b10 protects addresses whose top bit is one. Level 2'b11 protects all addresses.
- R11: During a write cycle the status byte stays readable, and bits 7, 3 and 2 keep their old values until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wren_i | input | 1 | Write-enable set strobe |
| wrdi_i | input | 1 | Write-enable clear strobe |
| sflb_i | input | 1 | Flag set strobe |
| rflb_i | input | 1 | Flag clear strobe |
| wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Status write data byte |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Write timer busy |
| chk_addr_i | input | ADDR_W | Array address to judge |
| status_o | output | 8 | Status byte for reads |
| array_wr_ok_o | output | 1 | Array write allowed at `chk_addr_i` |
| wrsr_go_o | output | 1 | Status write accepted; start the timer |

## Verification
The results fall due at different times. Write-in-progress, the accept pulse and the address permission are combinational, so they are due in the same cycle as the inputs that cause them. Latch and flag strobes show up after one rising edge. Nonvolatile bits and the write-enable clear show up after the rising edge at which busy is first seen low. The driver changes inputs only just after a falling edge and queues what is expected at that moment. The monitor compares 3 ns later, when every input has settled and every register has already taken the preceding rising edge. A check for a registered effect is therefore queued one falling edge after its stimulus, and a combinational check is queued while its stimulus is still held.

// File: rtl/nvm_status_pkg.sv
package nvm_status_pkg;
   localparam int SR_W     = 8;
   localparam int B_PEN    = 7;
   localparam int B_FLAG   = 6;
   localparam int B_LVL_HI = 3;
   localparam int B_LVL_LO = 2;
   localparam int B_WEL    = 1;
   localparam int B_WIP    = 0;
   // bits kept from a status write: protect-enable and level
   localparam logic [SR_W-1:0] NV_KEEP  = 8'b1000_1100;
   // fixed-one bits
   localparam logic [SR_W-1:0] FIX_ONES = 8'b0011_0000;

   typedef enum logic [1:0] {
      LVL_NONE = 2'b00,
      LVL_QTR  = 2'b01,
      LVL_HALF = 2'b10,
      LVL_ALL  = 2'b11
   } prot_lvl_e;
endpackage

// File: rtl/sr_volatile_bits.sv
module sr_volatile_bits (
   input  logic clk,
   input  logic rst_n,
   input  logic set_wel,
   input  logic clr_wel,
   input  logic cyc_done,
   input  logic set_flag,
   input  logic clr_flag,
   output logic wel,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (cyc_done || clr_wel)  wel <= 1'b0;
         else if (set_wel)         wel <= 1'b1;
         if (clr_flag)             flag <= 1'b0;
         else if (set_flag)        flag <= 1'b1;
      end
   end
endmodule

// File: rtl/sr_nv_stage.sv
module sr_nv_stage
   import nvm_status_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic [SR_W-1:0] wdata,
   input  logic            cyc_done,
   output logic [SR_W-1:0] nv_img
);
   logic [SR_W-1:0] hold_q;
   logic            hold_v;
   logic            commit;

   assign commit = cyc_done & hold_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         hold_v <= 1'b0;
         nv_img <= '0;
      end else begin
         if (commit) nv_img <= hold_q;
         if (accept) hold_q <= wdata & NV_KEEP;
         hold_v <= accept | (hold_v & ~cyc_done);
      end
   end
endmodule

// File: rtl/blk_prot_decode.sv
module blk_prot_decode
   import nvm_status_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  prot_lvl_e         lvl,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
   localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

   logic in_half, in_qtr;
   assign in_half = (addr >= HALF_BASE);
   assign in_qtr  = (addr >= QTR_BASE);

   always_comb begin
      unique case (lvl)
         LVL_NONE: locked = 1'b0;
         LVL_QTR:  locked = in_qtr;
         LVL_HALF: locked = in_half;
         default:  locked = 1'b1;
      endcase
   end
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
   import nvm_status_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_i,
   input  logic              wrdi_i,
   input  logic              sflb_i,
   input  logic              rflb_i,
   input  logic              wrsr_i,
   input  logic [7:0]        wrsr_data_i,
   input  logic              wp_n_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] chk_addr_i,
   output logic [7:0]        status_o,
   output logic              array_wr_ok_o,
   output logic              wrsr_go_o
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("nvm_status_guard: ADDR_W must be within 2..32");
      end
   endgenerate

   logic            busy_q, cyc_done;
   logic            wel, flag, pin_lock, locked;
   logic [SR_W-1:0] nv_img;
   prot_lvl_e       lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_i;
   end
   assign cyc_done = busy_q & ~busy_i;

   sr_volatile_bits u_vol (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_wel  (wren_i),
      .clr_wel  (wrdi_i),
      .cyc_done (cyc_done),
      .set_flag (sflb_i),
      .clr_flag (rflb_i),
      .wel      (wel),
      .flag     (flag)
   );

   assign pin_lock  = nv_img[B_PEN] & ~wp_n_i;
   assign wrsr_go_o = wrsr_i & wel & ~busy_i & ~pin_lock;

   sr_nv_stage u_nv (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (wrsr_go_o),
      .wdata    (wrsr_data_i),
      .cyc_done (cyc_done),
      .nv_img   (nv_img)
   );

   assign lvl = prot_lvl_e'(nv_img[B_LVL_HI:B_LVL_LO]);

   blk_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
      .lvl    (lvl),
      .addr   (chk_addr_i),
      .locked (locked)
   );

   always_comb begin
      status_o         = (nv_img & NV_KEEP) | FIX_ONES;
      status_o[B_FLAG] = flag;
      status_o[B_WEL]  = wel;
      status_o[B_WIP]  = busy_i;
   end

   assign array_wr_ok_o = wel & ~busy_i & ~locked;
endmodule

// File: rtl/nvm_status_guard_chk.sv
module nvm_status_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wrdi_i,
   input logic       wp_n_i,
   input logic       busy_i,
   input logic [7:0] status_o,
   input logic       array_wr_ok_o,
   input logic       wrsr_go_o
);
   assert_wip_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[0] == busy_i);

   assert_fixed_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[5:4] == 2'b11);

   assert_wrdi_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrdi_i |=> !status_o[1]);

   assert_go_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrsr_go_o |-> (status_o[1] && !busy_i));

   assert_pin_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[7] && !wp_n_i) |-> !wrsr_go_o);

   assert_all_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[3:2] == 2'b11) |-> !array_wr_ok_o);

   assert_done_clears_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |=> !status_o[1]);

   assert_nv_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i)) |-> $stable({status_o[7], status_o[3:2]}));
endmodule

bind nvm_status_guard nvm_status_guard_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wrdi_i        (wrdi_i),
   .wp_n_i        (wp_n_i),
   .busy_i        (busy_i),
   .status_o      (status_o),
   .array_wr_ok_o (array_wr_ok_o),
   .wrsr_go_o     (wrsr_go_o)
);

// File: tb/test_nvm_status_guard.sv
`timescale 1ns/1ps
module test_nvm_status_guard;
   localparam int AW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wren_i = 0, wrdi_i = 0, sflb_i = 0, rflb_i = 0, wrsr_i = 0;
   logic [7:0] wrsr_data_i = '0;
   logic wp_n_i = 1'b1, busy_i = 1'b0;
   logic [AW-1:0] chk_addr_i = '0;
   logic [7:0] status_o;
   logic array_wr_ok_o, wrsr_go_o;

   always #4 clk = ~clk;

   nvm_status_guard #(.ADDR_W(AW)) i_nvm_status_guard (
      .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
      .sflb_i(sflb_i), .rflb_i(rflb_i), .wrsr_i(wrsr_i),
      .wrsr_data_i(wrsr_data_i), .wp_n_i(wp_n_i), .busy_i(busy_i),
      .chk_addr_i(chk_addr_i), .status_o(status_o),
      .array_wr_ok_o(array_wr_ok_o), .wrsr_go_o(wrsr_go_o));

   typedef struct {
      string      tag;
      logic [7:0] st;
      logic       ok;
      logic       go;
   } exp_t;

   exp_t exp_q[$];
   int total = 0, bad = 0;
   bit finished = 0;

   task automatic expect_now(string tag, logic [7:0] st, logic ok, logic go);
      exp_t e;
      e.tag = tag; e.st = st; e.ok = ok; e.go = go;
      exp_q.push_back(e);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic commit_cycle();
      step(); wrsr_i = 0; busy_i = 1;
      step(); busy_i = 0;
      step();
   endtask

   // monitor: compares queued items 3 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (status_o !== e.st || array_wr_ok_o !== e.ok || wrsr_go_o !== e.go) begin
               bad++;
               $display("FAIL %s: status=%h ok=%b go=%b expected status=%h ok=%b go=%b",
                        e.tag, status_o, array_wr_ok_o, wrsr_go_o, e.st, e.ok, e.go);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      expect_now("R1 reset byte", 8'h30, 0, 0);
      // R3
      wren_i = 1; step(); wren_i = 0;
      expect_now("R3 set latch", 8'h32, 1, 0);
      wren_i = 1; wrdi_i = 1; step(); wren_i = 0; wrdi_i = 0;
      expect_now("R3 clear wins", 8'h30, 0, 0);
      // R4
      sflb_i = 1; step(); sflb_i = 0;
      expect_now("R4 flag set", 8'h70, 0, 0);
      sflb_i = 1; rflb_i = 1; step(); sflb_i = 0; rflb_i = 0;
      expect_now("R4 flag clear wins", 8'h30, 0, 0);
      // R5 refused without latch
      wrsr_i = 1; wrsr_data_i = 8'h8C;
      expect_now("R5 no latch no go", 8'h30, 0, 0);
      step(); wrsr_i = 0;
      expect_now("R5 refused write no change", 8'h30, 0, 0);
      // accepted write, pin falls during cycle
      wren_i = 1; step(); wren_i = 0;
      wrsr_i = 1; wrsr_data_i = 8'h8F;
      expect_now("R5 accept", 8'h32, 1, 1);
      step(); wrsr_i = 0; busy_i = 1;
      expect_now("R2 busy shows", 8'h33, 0, 0);
      step(); wp_n_i = 0;
      expect_now("R11 old bits while busy", 8'h33, 0, 0);
      step(); busy_i = 0;
      step();
      expect_now("R7 commit despite pin", 8'hBC, 0, 0);
      // pin lock active
      wren_i = 1; step(); wren_i = 0;
      wrsr_i = 1; wrsr_data_i = 8'h00;
      expect_now("R5 pin lock refuses", 8'hBE, 0, 0);
      step(); wrsr_i = 0; wp_n_i = 1;
      wrsr_i = 1;
      expect_now("R5 pin released accepts", 8'hBE, 0, 1);
      commit_cycle();
      expect_now("R6 commit clears latch", 8'h30, 0, 0);
      // R8: protect-enable zero, pin low ignored
      wp_n_i = 0;
      wren_i = 1; step(); wren_i = 0;
      wrsr_i = 1; wrsr_data_i = 8'h04;
      expect_now("R8 pin ignored", 8'h32, 1, 1);
      commit_cycle();
      expect_now("R6 quarter level", 8'h34, 0, 0);
      // R10 quarter
      wren_i = 1; step(); wren_i = 0;
      chk_addr_i = 13'h1FFF;
      expect_now("R10 quarter top", 8'h36, 0, 0);
      step(); chk_addr_i = 13'h1800;
      expect_now("R10 quarter base", 8'h36, 0, 0);
      step(); chk_addr_i = 13'h17FF;
      expect_now("R10 below quarter", 8'h36, 1, 0);
      step(); chk_addr_i = '0;
      wrsr_i = 1; wrsr_data_i = 8'h08;
      expect_now("R8 second accept", 8'h36, 1, 1);
      commit_cycle();
      expect_now("R6 half level", 8'h38, 0, 0);
      // R10 half
      wren_i = 1; step(); wren_i = 0;
      chk_addr_i = 13'h1000;
      expect_now("R10 half base", 8'h3A, 0, 0);
      step(); chk_addr_i = 13'h0FFF;
      expect_now("R10 below half", 8'h3A, 1, 0);
      step(); chk_addr_i = '0;
      // R9 ignored bits
      wrsr_i = 1; wrsr_data_i = 8'h73;
      expect_now("R9 accept", 8'h3A, 1, 1);
      commit_cycle();
      expect_now("R9 ignored bits", 8'h30, 0, 0);
      // R6 busy refusal and array-cycle completion
      wp_n_i = 1;
      wren_i = 1; step(); wren_i = 0;
      busy_i = 1; wrsr_i = 1; wrsr_data_i = 8'h0C;
      expect_now("R6 refused while busy", 8'h33, 0, 0);
      step(); wrsr_i = 0; busy_i = 0;
      step();
      expect_now("R6 array cycle clears latch", 8'h30, 0, 0);
      step(); step();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule